// File: doc/BRIEF.md
# Floating-Point Compare Unit

This block compares two IEEE-754 double-precision bit patterns and reports their relation as a one-hot, four-bit condition code. The compare itself is purely combinational on the raw bits. No conversion or normalisation takes place: the ordering follows directly from the sign bit and the 63-bit exponent-and-fraction magnitude. When a valid request is presented, the code is registered into two places. One is a status-code output. The other is one of eight four-bit fields of a 32-bit condition register, selected by a three-bit field index; the other seven fields keep their values.

Two compare flavours are supported. The ordered flavour reports an invalid-compare strobe whenever either operand is any kind of NaN. The unordered flavour stays silent on quiet NaNs. In both flavours, a signaling NaN on either side raises a signaling-NaN strobe. The surrounding pipeline merges these one-cycle strobes into its own status register; this block does not hold that register.

Top module: `fpcmp_unit`

## Requirements
- R1: While reset is asserted and after its release, `cr_out`, `fpcc_out`, `out_valid`, `vxvc_strobe` and `vxsnan_strobe` are all zero until the first accepted request.
- R2: The code is one-hot with less-than at bit 3, greater-than at bit 2, equal at bit 1 and unordered at bit 0 (LT=4'b1000, GT=4'b0100, EQ=4'b0010, UN=4'b0001); exactly one bit is set in every reported result.
- R3: A NaN operand is one with all exponent bits [62:52] set and a non-zero fraction [51:0]. If either operand is a NaN, the code is UN (4'b0001).
- R4: With `ordered`=1, `vxvc_strobe` pulses with the result whenever either operand is a NaN (quiet or signaling), and stays low otherwise.
- R5: In either flavour, `vxsnan_strobe` pulses with the result when either operand is a signaling NaN (a NaN with fraction bit 51 clear), and stays low for quiet NaNs and numbers.
- R6: With `ordered`=0, `vxvc_strobe` never pulses, not even for NaN operands.
- R7: +0 (64'h0) and -0 (64'h8000_0000_0000_0000) compare equal in any combination.
- R8: Non-NaN operands are ordered by value: a positive operand is greater than a negative one; for two positives the larger magnitude bits [62:0] is greater; for two negatives the order is reversed. Infinities take part as the largest magnitudes.
- R9: The code is written to `fpcc_out` and to CR field N, which is `cr_out[31-4N:28-4N]` (field 0 is the most significant nibble). All other CR fields keep their previous value.
- R10: `fpcc_out`, `cr_out` and the strobes reflect a request in the cycle after the edge that sampled `in_valid`=1; `out_valid` is high exactly then. Without `in_valid`, `out_valid` and both strobes are low, and `cr_out` and `fpcc_out` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| ordered | input | 1 | 1 = ordered compare, 0 = unordered compare |
| opa | input | 64 | First operand, double-precision bit pattern |
| opb | input | 64 | Second operand, double-precision bit pattern |
| dst_field | input | 3 | Destination condition-register field index |
| cr_out | output | 32 | Condition register, eight four-bit fields |
| fpcc_out | output | 4 | Latest condition code {LT,GT,EQ,UN} |
| out_valid | output | 1 | Result of a request registered this cycle |
| vxvc_strobe | output | 1 | Invalid-compare flag set request |
| vxsnan_strobe | output | 1 | Signaling-NaN flag set request |

## Verification
Several properties are checked on every cycle. The code is one-hot whenever a result is reported, and an invalid-compare strobe only comes with an unordered code. Unordered requests never raise it, and a signaling-NaN strobe implies an unordered code. The selected CR field always matches the status code, idle cycles hold both registers and keep the strobes low, and two zeros give the equal code. What only the directed scenarios can show is the value ordering itself: the reversal for two negatives, the placement of infinities, quiet versus signaling NaN classification, and that writes to one field leave the seven others intact across a sequence of requests. The bench derives these from real-number comparison and its own CR shadow copy.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

  typedef enum logic [3:0] {
    CC_LT = 4'b1000,
    CC_GT = 4'b0100,
    CC_EQ = 4'b0010,
    CC_UN = 4'b0001
  } fpc_code_e;

  typedef struct packed {
    logic nan;
    logic snan;
    logic zero;
  } fpc_class_t;

endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W-1:0] op_mag,
  output fpcmp_pkg::fpc_class_t   cls
);
  localparam int MAG_W = EXP_W + FRAC_W;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_all_ones;
  logic              frac_nonzero;

  assign exp_f        = op_mag[MAG_W-1 -: EXP_W];
  assign frac_f       = op_mag[FRAC_W-1:0];
  assign exp_all_ones = &exp_f;
  assign frac_nonzero = |frac_f;

  always_comb begin
    cls.nan  = exp_all_ones && frac_nonzero;
    // quiet marker is the top fraction bit
    cls.snan = exp_all_ones && frac_nonzero && !frac_f[FRAC_W-1];
    cls.zero = ~|op_mag;
  end
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0]  opa,
  input  logic [EXP_W+FRAC_W:0]  opb,
  input  fpcmp_pkg::fpc_class_t  cls_a,
  input  fpcmp_pkg::fpc_class_t  cls_b,
  output fpcmp_pkg::fpc_code_e   code
);
  import fpcmp_pkg::*;

  localparam int MAG_W = EXP_W + FRAC_W;
  localparam int W     = MAG_W + 1;

  function automatic fpc_code_e order_of(
    input logic [W-1:0] a,
    input logic [W-1:0] b,
    input fpc_class_t   ca,
    input fpc_class_t   cb
  );
    logic a_mag_bigger;
    a_mag_bigger = a[MAG_W-1:0] > b[MAG_W-1:0];
    if (ca.nan || cb.nan)                  return CC_UN;
    else if (ca.zero && cb.zero)           return CC_EQ;
    else if (a[W-1] != b[W-1])             return a[W-1] ? CC_LT : CC_GT;
    else if (a[MAG_W-1:0] == b[MAG_W-1:0]) return CC_EQ;
    else if (a_mag_bigger ^ a[W-1])        return CC_GT;
    else                                   return CC_LT;
  endfunction

  assign code = order_of(opa, opb, cls_a, cls_b);
endmodule

// File: rtl/fpcmp_unit.sv
module fpcmp_unit #(
  parameter int EXP_W   = 11,
  parameter int FRAC_W  = 52,
  parameter int NFIELD  = 8,
  parameter int FIELD_W = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic                         ordered,
  input  logic [EXP_W+FRAC_W:0]        opa,
  input  logic [EXP_W+FRAC_W:0]        opb,
  input  logic [$clog2(NFIELD)-1:0]    dst_field,
  output logic [NFIELD*FIELD_W-1:0]    cr_out,
  output logic [FIELD_W-1:0]           fpcc_out,
  output logic                         out_valid,
  output logic                         vxvc_strobe,
  output logic                         vxsnan_strobe
);
  import fpcmp_pkg::*;

  localparam int MAG_W       = EXP_W + FRAC_W;
  localparam int W           = MAG_W + 1;
  localparam int CR_W        = NFIELD * FIELD_W;
  localparam int FIELD_IDX_W = $clog2(NFIELD);

  // ---------------- operand classification ----------------
  logic [W-1:0]  ops [2];
  fpc_class_t    cls [2];

  assign ops[0] = opa;
  assign ops[1] = opb;

  for (genvar gi = 0; gi < 2; gi++) begin : g_cls
    fpcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .op_mag (ops[gi][MAG_W-1:0]),
      .cls    (cls[gi])
    );
  end

  // ---------------- ordering ----------------
  fpc_code_e cmp_code;

  fpcmp_order #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_order (
    .opa   (opa),
    .opb   (opb),
    .cls_a (cls[0]),
    .cls_b (cls[1]),
    .code  (cmp_code)
  );

  // ---------------- named events ----------------
  logic any_nan;
  logic any_snan;
  logic raise_vxvc;
  logic raise_vxsnan;
  logic both_zero;

  assign any_nan      = cls[0].nan  || cls[1].nan;
  assign any_snan     = cls[0].snan || cls[1].snan;
  assign both_zero    = cls[0].zero && cls[1].zero;
  assign raise_vxvc   = in_valid && ordered && any_nan;
  assign raise_vxsnan = in_valid && any_snan;

  // ---------------- CR field insertion ----------------
  logic [CR_W-1:0] cr_next;

  for (genvar gf = 0; gf < NFIELD; gf++) begin : g_field
    assign cr_next[CR_W-1-gf*FIELD_W -: FIELD_W] =
      (dst_field == FIELD_IDX_W'(gf)) ? FIELD_W'(cmp_code)
                                      : cr_out[CR_W-1-gf*FIELD_W -: FIELD_W];
  end

  function automatic logic [FIELD_W-1:0] field_of(
    input logic [CR_W-1:0]        cr,
    input logic [FIELD_IDX_W-1:0] idx
  );
    return cr[CR_W-1-int'(idx)*FIELD_W -: FIELD_W];
  endfunction

  // ---------------- result registers ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cr_out        <= '0;
      fpcc_out      <= '0;
      out_valid     <= 1'b0;
      vxvc_strobe   <= 1'b0;
      vxsnan_strobe <= 1'b0;
    end else begin
      out_valid     <= in_valid;
      vxvc_strobe   <= raise_vxvc;
      vxsnan_strobe <= raise_vxsnan;
      if (in_valid) begin
        cr_out   <= cr_next;
        fpcc_out <= FIELD_W'(cmp_code);
      end
    end
  end

  // ---------------- assertions ----------------
  AST_CODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(fpcc_out) == 1); // R2

  AST_NAN_UNORDERED: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && any_nan |=> fpcc_out == 4'b0001); // R3

  AST_VXVC_WITH_UN: assert property (@(posedge clk) disable iff (!rst_n)
    vxvc_strobe |-> out_valid && fpcc_out == 4'b0001); // R4

  AST_SNAN_WITH_UN: assert property (@(posedge clk) disable iff (!rst_n)
    vxsnan_strobe |-> out_valid && fpcc_out[0]); // R5

  AST_NO_VXVC_UNORD: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !ordered |=> !vxvc_strobe); // R6

  AST_ZERO_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && both_zero |=> fpcc_out == 4'b0010); // R7

  AST_FIELD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> field_of(cr_out, $past(dst_field)) == fpcc_out); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !vxvc_strobe && !vxsnan_strobe); // R10

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(cr_out) && $stable(fpcc_out)); // R10

endmodule

// File: tb/fpcmp_unit_tb.sv
module fpcmp_unit_tb;
  localparam logic [63:0] P_ZERO = 64'h0000_0000_0000_0000;
  localparam logic [63:0] N_ZERO = 64'h8000_0000_0000_0000;
  localparam logic [63:0] P_ONE  = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] P_TWO  = 64'h4000_0000_0000_0000;
  localparam logic [63:0] N_ONE  = 64'hBFF0_0000_0000_0000;
  localparam logic [63:0] N_TWO  = 64'hC000_0000_0000_0000;
  localparam logic [63:0] P_INF  = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] N_INF  = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] QNAN   = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] SNAN   = 64'h7FF0_0000_0000_0001;
  localparam logic [63:0] P_MAX  = 64'h7FEF_FFFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        ordered = 1'b0;
  logic [63:0] opa = '0;
  logic [63:0] opb = '0;
  logic [2:0]  dst_field = '0;
  logic [31:0] cr_out;
  logic [3:0]  fpcc_out;
  logic        out_valid;
  logic        vxvc_strobe;
  logic        vxsnan_strobe;

  int n_checks = 0;
  int n_errors = 0;
  logic [31:0] exp_cr = '0;
  bit done = 0;

  always #4 clk = ~clk;

  fpcmp_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ordered(ordered),
    .opa(opa), .opb(opb), .dst_field(dst_field), .cr_out(cr_out),
    .fpcc_out(fpcc_out), .out_valid(out_valid), .vxvc_strobe(vxvc_strobe),
    .vxsnan_strobe(vxsnan_strobe)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] expv, input string what);
    n_checks++;
    if (act !== expv) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", what, act, expv);
    end
  endtask

  function automatic bit is_nan(input logic [63:0] v);
    return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
  endfunction

  function automatic bit is_snan(input logic [63:0] v);
    return is_nan(v) && !v[51];
  endfunction

  function automatic logic [3:0] ref_code(input logic [63:0] a, input logic [63:0] b);
    real ra, rb;
    if (is_nan(a) || is_nan(b)) return 4'b0001;
    ra = $bitstoreal(a);
    rb = $bitstoreal(b);
    if (ra < rb) return 4'b1000;
    if (ra > rb) return 4'b0100;
    return 4'b0010;
  endfunction

  // one request; result sampled at the next falling edge
  task automatic run_cmp(input logic [63:0] a, input logic [63:0] b,
                         input logic ord, input logic [2:0] f, input string tag);
    logic [3:0] ec;
    ec = ref_code(a, b);
    @(negedge clk);
    opa = a; opb = b; ordered = ord; dst_field = f; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    exp_cr[31-4*f -: 4] = ec;
    check({28'd0, fpcc_out}, {28'd0, ec}, {tag, " code"});
    check(cr_out, exp_cr, {tag, " cr R9"});
    check({31'd0, out_valid}, 32'd1, {tag, " out_valid R10"});
    check({31'd0, vxvc_strobe}, {31'd0, ord && (is_nan(a) || is_nan(b))}, {tag, " vxvc R4 R6"});
    check({31'd0, vxsnan_strobe}, {31'd0, is_snan(a) || is_snan(b)}, {tag, " vxsnan R5"});
  endtask

  task automatic t_reset();
    check(cr_out, 32'd0, "R1 cr reset");
    check({28'd0, fpcc_out}, 32'd0, "R1 fpcc reset");
    check({29'd0, out_valid, vxvc_strobe, vxsnan_strobe}, 32'd0, "R1 strobes reset");
  endtask

  task automatic t_basic();
    run_cmp(P_ONE, P_TWO, 1'b1, 3'd0, "R2 R8 1<2");
    run_cmp(P_TWO, P_ONE, 1'b0, 3'd1, "R2 R8 2>1");
    run_cmp(P_TWO, P_TWO, 1'b1, 3'd2, "R2 R8 2==2");
    run_cmp(N_ONE, P_ONE, 1'b0, 3'd3, "R8 -1<1");
  endtask

  task automatic t_negatives();
    run_cmp(N_TWO, N_ONE, 1'b1, 3'd4, "R8 -2<-1");
    run_cmp(N_ONE, N_TWO, 1'b0, 3'd5, "R8 -1>-2");
  endtask

  task automatic t_zeros();
    run_cmp(P_ZERO, N_ZERO, 1'b1, 3'd6, "R7 +0==-0");
    run_cmp(N_ZERO, P_ZERO, 1'b0, 3'd7, "R7 -0==+0");
    run_cmp(N_ZERO, P_ONE, 1'b0, 3'd0, "R7 -0<1");
  endtask

  task automatic t_infinities();
    run_cmp(P_INF, P_MAX, 1'b1, 3'd1, "R8 +inf>max");
    run_cmp(N_INF, N_TWO, 1'b0, 3'd2, "R8 -inf<-2");
    run_cmp(P_INF, P_INF, 1'b1, 3'd3, "R8 inf==inf");
    run_cmp(N_INF, P_INF, 1'b0, 3'd4, "R8 -inf<+inf");
  endtask

  task automatic t_nans();
    run_cmp(QNAN, P_ONE, 1'b1, 3'd5, "R3 R4 qnan ordered");
    run_cmp(P_ONE, QNAN, 1'b0, 3'd6, "R3 R6 qnan unordered");
    run_cmp(SNAN, P_ONE, 1'b0, 3'd7, "R5 R6 snan unordered");
    run_cmp(P_ZERO, SNAN, 1'b1, 3'd0, "R4 R5 snan ordered");
    run_cmp(QNAN, QNAN, 1'b0, 3'd1, "R3 both nan");
  endtask

  task automatic t_fields();
    for (int f = 0; f < 8; f++) begin
      run_cmp((f % 2 == 0) ? P_ONE : P_TWO, P_ONE, f[0], 3'(f), "R9 field walk");
    end
  endtask

  task automatic t_idle();
    logic [31:0] cr_before;
    logic [3:0]  cc_before;
    cr_before = cr_out;
    cc_before = fpcc_out;
    @(negedge clk);
    opa = N_ONE; opb = P_ONE; dst_field = 3'd3; ordered = 1'b1;
    @(negedge clk);
    check(cr_out, cr_before, "R10 idle cr hold");
    check({28'd0, fpcc_out}, {28'd0, cc_before}, "R10 idle fpcc hold");
    check({29'd0, out_valid, vxvc_strobe, vxsnan_strobe}, 32'd0, "R10 idle strobes low");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_negatives();
    t_zeros();
    t_infinities();
    t_nans();
    t_fields();
    t_idle();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog R10: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule